// File: doc/BRIEF.md
# Floppy controller command/result sequencer

This block is the host-facing front end of a floppy disk controller. The host sees two byte-wide ports. Address 0 is a read-only main status byte. Address 1 is a data port. The host pushes command bytes into the data port one at a time and later pulls result bytes out of it one at a time. The low five bits of the opening byte give the operation, and that operation fixes how many bytes the host must supply and how many it gets back. The status byte always shows which phase the sequencer is in: collecting bytes, executing, or handing back results.

Once the last command byte arrives, the sequencer gives a one-cycle start pulse to an external execution unit. The pulse carries the operation code, the selected drive and every byte the host wrote. The execution unit does the media work. It then raises a done strobe together with up to seven result bytes. The sequencer captures those bytes and presents as many of them as the operation defines, in slot order. Reading the final one returns the controller to idle. Operation codes the sequencer does not recognise never reach the execution unit. The sequencer answers them by itself with an invalid-command status byte.

Top module: `fdc_seq`

## Requirements
- R1: During and right after reset the status byte reads 0x80 and `exec_start` is low.
- R2: Status byte layout, from bit 7 down: request (7), direction with 1 = controller to host (6), non-DMA (5, always 0), controller busy (4), then one busy bit for each of drives 3..0 (3:0). It reads 0x80 when idle and 0x90 while command bytes are being collected. While the execution unit runs, bit 7 is 0, bit 6 is 0 and bit 4 is 1. It reads 0xD0 while results are pending.
- R3: The operation is decoded from bits 4:0 of the first data byte only. Bits 7:5 (multitrack, MFM, skip) do not change the decode, and `exec_cmd` equals bits 4:0.
- R4: Total command bytes per operation: 1 for sense interrupt (0x08). 2 for recalibrate (0x07), sense drive (0x04) and read ID (0x0A). 3 for specify (0x03) and seek (0x0F). 6 for format (0x0D). 9 for read (0x06), write (0x05), read track (0x02), write deleted (0x09) and read deleted (0x0C).
- R5: For every operation that takes a second byte, except specify, bits 1:0 of that byte pick the drive. The drive appears on `exec_drive`, and during execution its busy bit is the only one set in status bits 3:0. Specify and sense interrupt set no drive busy bit.
- R6: After the final command byte, `exec_start` is high for exactly one cycle. While it is high, `cmd_bytes` holds command byte i at bits [8i+7:8i].
- R7: Result bytes per operation: 7 for the five read/write operations, format and read ID. 2 for sense interrupt. 1 for sense drive. 0 for specify, seek and recalibrate, which go straight from execution to idle (0x80) when `exec_done` arrives.
- R8: The k-th data read in the result phase returns result slot k, taken from bits [8k+7:8k] of `exec_res` at `exec_done`. Reading the last defined byte returns the status byte to 0x80.
- R9: An unrecognised operation code starts no execution. The status byte moves straight to 0xD0, exactly one result byte 0x80 is returned, and the sequencer then goes idle.
- R10: A data read while command bytes are being collected drops the partial command and returns to idle, so the next data write is taken as a first byte.
- R11: Writes to the status port, data writes during the result phase, and any host access during execution are ignored. The status byte, the pending result position and the execution state stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | 1 | Port select: 0 status, 1 data |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte of the addressed port (combinational) |
| exec_start | output | 1 | One-cycle pulse that starts the execution unit |
| exec_cmd | output | 5 | Decoded operation code |
| exec_drive | output | 2 | Selected drive |
| cmd_bytes | output | 72 | All command bytes, byte i at bits [8i+7:8i] |
| exec_done | input | 1 | Execution unit finished; result bytes valid |
| exec_res | input | 56 | Result slots, slot k at bits [8k+7:8k] |

## Verification
The embedded assertions check on every cycle that the status byte's request and direction bits never disagree, that at most one drive busy bit is set, and that the start pulse is single-cycle and only occurs in execution. They also check that writes to the status port or in the result phase leave the phase and the result position untouched, and that an unrecognised operation never starts execution. The per-operation byte counts, the slot order of the returned results, the abort on an early data read and the upper-bit independence of decoding can only be shown by the bench's directed and random command sequences.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

  localparam int CNT_W = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CMD  = 2'd1,
    PH_EXEC = 2'd2,
    PH_RES  = 2'd3
  } phase_e;

  localparam logic [4:0] OP_RD_TRACK  = 5'h02;
  localparam logic [4:0] OP_SPECIFY   = 5'h03;
  localparam logic [4:0] OP_SENSE_DRV = 5'h04;
  localparam logic [4:0] OP_WRITE     = 5'h05;
  localparam logic [4:0] OP_READ      = 5'h06;
  localparam logic [4:0] OP_RECAL     = 5'h07;
  localparam logic [4:0] OP_SENSE_INT = 5'h08;
  localparam logic [4:0] OP_WRITE_DEL = 5'h09;
  localparam logic [4:0] OP_READ_ID   = 5'h0A;
  localparam logic [4:0] OP_READ_DEL  = 5'h0C;
  localparam logic [4:0] OP_FORMAT    = 5'h0D;
  localparam logic [4:0] OP_SEEK      = 5'h0F;

  localparam logic [7:0] ST0_BAD_OP = 8'h80;

  typedef struct packed {
    logic             valid;
    logic [CNT_W-1:0] n_cmd;
    logic [CNT_W-1:0] n_res;
    logic             uses_drive;
  } op_info_t;

endpackage

// File: rtl/fdc_cmd_decode.sv
module fdc_cmd_decode
  import fdc_seq_pkg::*;
(
  input  logic [4:0] code_i,
  output op_info_t   info_o
);

  always_comb begin
    info_o = '{valid: 1'b1, n_cmd: 4'd9, n_res: 4'd7, uses_drive: 1'b1};
    case (code_i)
      OP_RD_TRACK, OP_WRITE, OP_READ, OP_WRITE_DEL, OP_READ_DEL: ;
      OP_FORMAT:    info_o.n_cmd = 4'd6;
      OP_READ_ID:   info_o.n_cmd = 4'd2;
      OP_SENSE_DRV: begin info_o.n_cmd = 4'd2; info_o.n_res = 4'd1; end
      OP_RECAL:     begin info_o.n_cmd = 4'd2; info_o.n_res = 4'd0; end
      OP_SEEK:      begin info_o.n_cmd = 4'd3; info_o.n_res = 4'd0; end
      OP_SPECIFY: begin
        info_o.n_cmd      = 4'd3;
        info_o.n_res      = 4'd0;
        info_o.uses_drive = 1'b0;
      end
      OP_SENSE_INT: begin
        info_o.n_cmd      = 4'd1;
        info_o.n_res      = 4'd2;
        info_o.uses_drive = 1'b0;
      end
      default: info_o = '{valid: 1'b0, n_cmd: 4'd1, n_res: 4'd1, uses_drive: 1'b0};
    endcase
  end

endmodule

// File: rtl/fdc_msr_gen.sv
module fdc_msr_gen
  import fdc_seq_pkg::*;
#(
  parameter  int NUM_DRV = 4,
  localparam int DRV_W   = $clog2(NUM_DRV)
) (
  input  phase_e           phase_i,
  input  logic [DRV_W-1:0] drive_i,
  input  logic             show_drv_i,
  output logic [7:0]       msr_o
);

  logic [NUM_DRV-1:0] drv_busy;
  logic               rqm;
  logic               dio;
  logic               cb;

  for (genvar g = 0; g < NUM_DRV; g++) begin : g_drv
    assign drv_busy[g] = (phase_i == PH_EXEC) && show_drv_i && (drive_i == DRV_W'(g));
  end

  assign rqm   = (phase_i != PH_EXEC);
  assign dio   = (phase_i == PH_RES);
  assign cb    = (phase_i != PH_IDLE);
  assign msr_o = {rqm, dio, 1'b0, cb, 4'(drv_busy)};

endmodule

// File: rtl/fdc_result_buf.sv
module fdc_result_buf
  import fdc_seq_pkg::*;
#(
  parameter  int MAX_RES = 7,
  localparam int IDX_W   = $clog2(MAX_RES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic                    bad_i,
  input  logic                    pop_i,
  input  logic [MAX_RES-1:0][7:0] res_i,
  input  logic [CNT_W-1:0]        n_res_i,
  output logic [7:0]              byte_o,
  output logic                    last_o,
  output logic [IDX_W-1:0]        idx_o
);

  logic [MAX_RES-1:0][7:0] slot_q;
  logic [IDX_W-1:0]        idx_q;
  logic [IDX_W-1:0]        idx_d;

  always_comb begin
    idx_d = idx_q;
    if (load_i || bad_i) idx_d = '0;
    else if (pop_i)      idx_d = idx_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  always_ff @(posedge clk) begin
    if (load_i)     slot_q    <= res_i;
    else if (bad_i) slot_q[0] <= ST0_BAD_OP;
  end

  assign byte_o = (CNT_W'(idx_q) < CNT_W'(MAX_RES)) ? slot_q[idx_q] : 8'h00;
  assign last_o = (CNT_W'(idx_q) == (n_res_i - CNT_W'(1)));
  assign idx_o  = idx_q;

  // R8
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !load_i && !bad_i) |=> (idx_q == $past(idx_q) + IDX_W'(1)));

endmodule

// File: rtl/fdc_seq.sv
module fdc_seq
  import fdc_seq_pkg::*;
#(
  parameter  int NUM_DRV = 4,
  parameter  int MAX_CMD = 9,
  parameter  int MAX_RES = 7,
  localparam int DRV_W   = $clog2(NUM_DRV),
  localparam int IDX_W   = $clog2(MAX_RES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_addr,
  input  logic                 host_wr,
  input  logic                 host_rd,
  input  logic [7:0]           host_wdata,
  output logic [7:0]           host_rdata,
  output logic                 exec_start,
  output logic [4:0]           exec_cmd,
  output logic [DRV_W-1:0]     exec_drive,
  output logic [MAX_CMD*8-1:0] cmd_bytes,
  input  logic                 exec_done,
  input  logic [MAX_RES*8-1:0] exec_res
);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  phase_e                  phase_q, phase_d;
  logic [4:0]              code_q, code_d;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic [DRV_W-1:0]        drive_q, drive_d;
  logic                    start_q, start_d;
  logic [MAX_CMD-1:0][7:0] prm_q;

  logic             data_wr, data_rd;
  logic [4:0]       dec_code;
  op_info_t         info;
  logic             prm_we;
  logic [CNT_W-1:0] prm_idx;
  logic             res_load, res_bad, res_pop;
  logic [7:0]       res_byte;
  logic             res_last;
  logic [IDX_W-1:0] res_idx;
  logic [7:0]       msr;

  assign data_wr  = host_wr && host_addr;
  assign data_rd  = host_rd && host_addr;
  assign dec_code = (phase_q == PH_IDLE) ? host_wdata[4:0] : code_q;

  fdc_cmd_decode u_dec (
    .code_i (dec_code),
    .info_o (info)
  );

  fdc_msr_gen #(.NUM_DRV(NUM_DRV)) u_msr (
    .phase_i    (phase_q),
    .drive_i    (drive_q),
    .show_drv_i (info.uses_drive),
    .msr_o      (msr)
  );

  fdc_result_buf #(.MAX_RES(MAX_RES)) u_res (
    .clk     (clk),
    .rst_n   (rst_ns),
    .load_i  (res_load),
    .bad_i   (res_bad),
    .pop_i   (res_pop),
    .res_i   (exec_res),
    .n_res_i (info.n_res),
    .byte_o  (res_byte),
    .last_o  (res_last),
    .idx_o   (res_idx)
  );

  // next-state
  always_comb begin
    phase_d  = phase_q;
    code_d   = code_q;
    cnt_d    = cnt_q;
    drive_d  = drive_q;
    start_d  = 1'b0;
    res_load = 1'b0;
    res_bad  = 1'b0;
    res_pop  = 1'b0;
    prm_we   = 1'b0;
    prm_idx  = cnt_q;
    case (phase_q)
      PH_IDLE: begin
        if (data_wr) begin
          prm_we  = 1'b1;
          prm_idx = '0;
          code_d  = host_wdata[4:0];
          cnt_d   = CNT_W'(1);
          if (!info.valid) begin
            phase_d = PH_RES;
            res_bad = 1'b1;
          end else if (info.n_cmd == CNT_W'(1)) begin
            phase_d = PH_EXEC;
            start_d = 1'b1;
          end else begin
            phase_d = PH_CMD;
          end
        end
      end
      PH_CMD: begin
        if (data_wr) begin
          prm_we = 1'b1;
          cnt_d  = cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(1) && info.uses_drive) drive_d = host_wdata[DRV_W-1:0];
          if (cnt_q + CNT_W'(1) == info.n_cmd) begin
            phase_d = PH_EXEC;
            start_d = 1'b1;
          end
        end else if (data_rd) begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end
      end
      PH_EXEC: begin
        if (exec_done) begin
          res_load = 1'b1;
          phase_d  = (info.n_res == '0) ? PH_IDLE : PH_RES;
        end
      end
      PH_RES: begin
        if (data_rd) begin
          res_pop = 1'b1;
          if (res_last) phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      phase_q <= PH_IDLE;
      code_q  <= '0;
      cnt_q   <= '0;
      drive_q <= '0;
      start_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      code_q  <= code_d;
      cnt_q   <= cnt_d;
      drive_q <= drive_d;
      start_q <= start_d;
    end
  end

  // command byte store, enable only
  always_ff @(posedge clk) begin
    for (int i = 0; i < MAX_CMD; i++) begin
      if (prm_we && prm_idx == CNT_W'(i)) prm_q[i] <= host_wdata;
    end
  end

  assign host_rdata = !host_addr ? msr : ((phase_q == PH_RES) ? res_byte : 8'h00);
  assign exec_start = start_q;
  assign exec_cmd   = code_q;
  assign exec_drive = drive_q;
  assign cmd_bytes  = prm_q;

  // R2
  dir_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    msr[6] |-> msr[7]);

  // R5
  one_drive_busy_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $onehot0(msr[3:0]));

  // R6
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    start_q |=> !start_q);

  // R6
  start_in_exec_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    start_q |-> (msr[7] == 1'b0 && msr[4] == 1'b1));

  // R9
  bad_op_no_start_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (phase_q == PH_RES && !info.valid) |-> !start_q);

  // R11
  status_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (host_wr && !host_addr && !host_rd && !exec_done) |=> ($stable(phase_q) && $stable(cnt_q)));

  // R11
  result_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (phase_q == PH_RES && host_wr && host_addr && !host_rd) |=> (phase_q == PH_RES && $stable(res_idx)));

endmodule

// File: tb/tb_fdc_seq.sv
module tb_fdc_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_addr;
  logic        host_wr;
  logic        host_rd;
  logic [7:0]  host_wdata;
  logic [7:0]  host_rdata;
  logic        exec_start;
  logic [4:0]  exec_cmd;
  logic [1:0]  exec_drive;
  logic [71:0] cmd_bytes;
  logic        exec_done;
  logic [55:0] exec_res;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  fdc_seq dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .exec_start (exec_start),
    .exec_cmd   (exec_cmd),
    .exec_drive (exec_drive),
    .cmd_bytes  (cmd_bytes),
    .exec_done  (exec_done),
    .exec_res   (exec_res)
  );

  function automatic int n_cmd_of(input logic [4:0] c);
    case (c)
      5'h08:                      return 1;
      5'h07, 5'h04, 5'h0A:        return 2;
      5'h03, 5'h0F:               return 3;
      5'h0D:                      return 6;
      5'h02, 5'h05, 5'h06, 5'h09, 5'h0C: return 9;
      default:                    return 1;
    endcase
  endfunction

  function automatic int n_res_of(input logic [4:0] c);
    case (c)
      5'h02, 5'h05, 5'h06, 5'h09, 5'h0C, 5'h0D, 5'h0A: return 7;
      5'h08:                      return 2;
      5'h04:                      return 1;
      5'h03, 5'h07, 5'h0F:        return 0;
      default:                    return 1;
    endcase
  endfunction

  function automatic bit known_op(input logic [4:0] c);
    case (c)
      5'h02, 5'h03, 5'h04, 5'h05, 5'h06, 5'h07, 5'h08, 5'h09,
      5'h0A, 5'h0C, 5'h0D, 5'h0F: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit has_drive(input logic [4:0] c);
    return known_op(c) && c != 5'h03 && c != 5'h08;
  endfunction

  task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    host_addr  = a;
    host_wdata = d;
    host_wr    = 1'b1;
    @(negedge clk);
    host_wr    = 1'b0;
    host_addr  = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    host_addr = a;
    host_rd   = 1'b1;
    #1 v = host_rdata;
    @(negedge clk);
    host_rd   = 1'b0;
    host_addr = 1'b0;
  endtask

  task automatic get_msr(output logic [7:0] v);
    host_addr = 1'b0;
    #1 v = host_rdata;
  endtask

  // res_poke: result position before which a data write is injected (-1 none)
  task automatic run_cmd(input logic [7:0] op, input int res_poke, input bit exec_poke);
    logic [4:0]  c;
    int          n;
    int          nr;
    logic [7:0]  b [9];
    logic [7:0]  v;
    logic [7:0]  m;
    logic [7:0]  exp_msr;
    logic [55:0] rw;
    c = op[4:0];
    n = n_cmd_of(c);
    nr = n_res_of(c);
    for (int i = 0; i < 9; i++) b[i] = (i == 0) ? op : 8'($urandom());
    for (int i = 0; i < n; i++) begin
      wr(1'b1, b[i]);
      if (i < n - 1) begin
        get_msr(m);
        check($sformatf("R4 msr mid-command op=%0h byte=%0d", c, i), 72'(m), 72'h90);
      end
    end
    if (!known_op(c)) begin
      get_msr(m);
      check($sformatf("R9 msr after bad op %0h", c), 72'(m), 72'hD0);
      check("R9 no start on bad op", 72'(exec_start), 72'h0);
      rd(1'b1, v);
      check("R9 bad op status byte", 72'(v), 72'h80);
      get_msr(m);
      check("R9 idle after bad op", 72'(m), 72'h80);
      return;
    end
    check($sformatf("R6 start pulse op=%0h", c), 72'(exec_start), 72'h1);
    check($sformatf("R3 exec_cmd op=%0h", op), 72'(exec_cmd), 72'(c));
    for (int i = 0; i < n; i++)
      check($sformatf("R6 cmd byte %0d", i), 72'(cmd_bytes[8*i +: 8]), 72'(b[i]));
    exp_msr = 8'h10;
    if (has_drive(c)) begin
      check($sformatf("R5 exec_drive op=%0h", c), 72'(exec_drive), 72'(b[1][1:0]));
      exp_msr = exp_msr | (8'h01 << b[1][1:0]);
    end
    get_msr(m);
    check($sformatf("R2 R5 msr in execution op=%0h", c), 72'(m), 72'(exp_msr));
    @(negedge clk);
    check("R6 start lasts one cycle", 72'(exec_start), 72'h0);
    if (exec_poke) begin
      wr(1'b1, 8'hA5);
      wr(1'b0, 8'h3C);
      get_msr(m);
      check("R11 host writes in execution ignored", 72'(m), 72'(exp_msr));
    end
    repeat ($urandom_range(0, 3)) @(negedge clk);
    rw = {24'($urandom()), $urandom()};
    exec_res  = rw;
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
    get_msr(m);
    check($sformatf("R7 msr after done op=%0h", c), 72'(m), (nr == 0) ? 72'h80 : 72'hD0);
    for (int j = 0; j < nr; j++) begin
      if (j == res_poke) begin
        wr(1'b1, 8'h55);
        wr(1'b0, 8'h66);
        get_msr(m);
        check("R11 writes in result phase ignored", 72'(m), 72'hD0);
      end
      rd(1'b1, v);
      check($sformatf("R8 result slot %0d op=%0h", j, c), 72'(v), 72'(rw[8*j +: 8]));
      get_msr(m);
      check($sformatf("R8 msr after result %0d", j), 72'(m), (j == nr - 1) ? 72'h80 : 72'hD0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] m;
    logic [7:0] v;
    logic [4:0] ops [14];
    ops = '{5'h02, 5'h03, 5'h04, 5'h05, 5'h06, 5'h07, 5'h08,
            5'h09, 5'h0A, 5'h0C, 5'h0D, 5'h0F, 5'h01, 5'h1F};
    void'($urandom(32'd20241));
    rst_n      = 1'b0;
    host_addr  = 1'b0;
    host_wr    = 1'b0;
    host_rd    = 1'b0;
    host_wdata = 8'h00;
    exec_done  = 1'b0;
    exec_res   = '0;
    repeat (3) @(negedge clk);
    get_msr(m);
    check("R1 msr in reset", 72'(m), 72'h80);
    check("R1 start low in reset", 72'(exec_start), 72'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    get_msr(m);
    check("R1 msr after reset", 72'(m), 72'h80);

    // status port write ignored
    wr(1'b0, 8'h06);
    get_msr(m);
    check("R11 status write ignored", 72'(m), 72'h80);

    // directed command set
    run_cmd(8'h04, -1, 1'b0);
    run_cmd(8'h08, -1, 1'b0);
    run_cmd(8'h03, -1, 1'b0);
    run_cmd(8'h0F, -1, 1'b1);
    run_cmd(8'hE6, -1, 1'b0);
    run_cmd(8'h45, 2, 1'b0);
    run_cmd(8'h0D, -1, 1'b0);
    run_cmd(8'h1F, -1, 1'b0);
    run_cmd(8'hE1, -1, 1'b0);

    // early data read during command collection
    wr(1'b1, 8'h06);
    wr(1'b1, 8'h01);
    rd(1'b1, v);
    get_msr(m);
    check("R10 abort on data read", 72'(m), 72'h80);
    run_cmd(8'h07, -1, 1'b0);

    for (int k = 0; k < 60; k++) begin
      logic [4:0] c;
      int         poke;
      c = ops[$urandom_range(0, 13)];
      poke = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 6) : -1;
      run_cmd({3'($urandom()), c}, poke, 1'($urandom()));
    end

    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule